// File: doc/BRIEF.md
# Two-Stage Pipelined GF(2^8) Multiplier

This block multiplies two variable elements of the finite field GF(2^8) and delivers their product two clock cycles later. It takes a new operand pair on every clock. No logarithm or antilogarithm tables are used. The first stage forms the carry-less (polynomial) product of the two operands from AND terms folded by XOR. The second stage folds the upper half of that product back into the field, using the residues of the high powers of x modulo the field polynomial x^8+x^4+x^3+x^2+1 (0x11D). Those residues are computed at elaboration time.

One register bank holds the 15-bit carry-less product between the two halves. A second bank holds the reduced 8-bit result at the output. A valid bit runs alongside the data through both banks. A data register loads only when its valid bit is set, so the last result stays on the output while no new result arrives. The block is meant to sit inside error-correction datapaths, such as syndrome, locator and evaluator arithmetic. There it replaces table-based multipliers with a short, fixed-depth XOR network.

Top module: `gf_mul_pipe`

## Requirements
- R1: When `in_valid` is high with operands a and b at a rising edge, `p_out` equals a·b in GF(2^8) modulo x^8+x^4+x^3+x^2+1 (0x11D) while `out_valid` is high, two rising edges later. Bit i of an operand is the coefficient of x^i.
- R2: `out_valid` is high after a rising edge exactly when `in_valid` was high at the rising edge two edges earlier and no reset occurred in between. No result is dropped, duplicated or reordered.
- R3: A new operand pair is accepted on every clock: N back-to-back valid inputs produce N consecutive cycles of `out_valid` high.
- R4: If either operand is 0x00, the result is 0x00.
- R5: If either operand is 0x01, the result equals the other operand.
- R6: A synchronous active-high `rst` clears both pipeline stages. After a rising edge with `rst` high, `out_valid` is 0 and `p_out` is 0x00, and operands that were in flight never appear at the output.
- R7: While `out_valid` is low, `p_out` keeps the last valid result (or 0x00 after reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair on `a_in`/`b_in` is valid |
| a_in | input | 8 | First field operand |
| b_in | input | 8 | Second field operand |
| out_valid | output | 1 | `p_out` carries a new product |
| p_out | output | 8 | Registered field product |

## Verification
The hardest case to reach from the ports is a synchronous reset that lands while both pipeline banks hold live operands. That state exists for only two cycles, and only in the middle of a dense burst. The stimulus drives an unbroken burst, raises `rst` at a chosen cycle, and then checks that none of the in-flight products ever comes out. The arithmetic itself is covered by all 65536 operand pairs, compared against a log/antilog model in the bench. Periodic bubbles separate long back-to-back runs, and a second phase uses pseudo-random gaps to vary how occupied the pipeline is.

// File: rtl/gf_mul_pkg.sv
package gf_mul_pkg;
  // Symbol width and field polynomial (x^8+x^4+x^3+x^2+1), including the x^8 term
  parameter int          SYM_W    = 8;
  parameter logic [8:0]  FIELD_PY = 9'h11D;
  // Width of the un-reduced carry-less product
  localparam int         CLP_W    = 2 * SYM_W - 1;
endpackage

// File: rtl/gf_clmul.sv
// Carry-less polynomial product of two SYM_W-bit operands (AND terms folded by XOR)
module gf_clmul #(
  parameter int W  = 8,
  localparam int PW = 2 * W - 1,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  output logic [PW-1:0] clp
);

  // One XOR column per product bit: bit k collects every a[i]&b[k-i]
  for (genvar k = 0; k < PW; k++) begin : g_col
    always_comb begin
      logic acc;
      acc = 1'b0;
      for (int i = 0; i < W; i++) begin
        int j;
        j = k - i;
        if (j >= 0 && j < W) begin
          acc = acc ^ (op_a[i] & op_b[j[IW-1:0]]);
        end
      end
      clp[k] = acc;
    end
  end

endmodule

// File: rtl/gf_reduce.sv
// Folds a carry-less product back into the field: each high bit contributes the
// residue of its power of x modulo the polynomial, computed at elaboration.
module gf_reduce #(
  parameter int        W    = 8,
  parameter logic [W:0] POLY = 9'h11D,
  localparam int       PW   = 2 * W - 1,
  localparam int       HN   = W - 1
) (
  input  logic [PW-1:0] clp,
  output logic [W-1:0]  sym
);

  // x^n mod POLY, n >= 0
  function automatic logic [W-1:0] xpow(input int n);
    logic [W-1:0] r;
    r = {{(W-1){1'b0}}, 1'b1};
    for (int s = 0; s < n; s++) begin
      if (r[W-1]) r = (r << 1) ^ POLY[W-1:0];
      else        r = r << 1;
    end
    return r;
  endfunction

  // Residue masks for x^W .. x^(2W-2), packed one symbol per slot
  function automatic logic [HN*W-1:0] build_masks();
    logic [HN*W-1:0] m;
    m = '0;
    for (int h = 0; h < HN; h++) begin
      m[h*W +: W] = xpow(W + h);
    end
    return m;
  endfunction

  localparam logic [HN*W-1:0] MASKS = build_masks();

  for (genvar m = 0; m < W; m++) begin : g_bit
    always_comb begin
      logic acc;
      acc = clp[m];
      for (int h = 0; h < HN; h++) begin
        acc = acc ^ (clp[W + h] & MASKS[h*W + m]);
      end
      sym[m] = acc;
    end
  end

endmodule

// File: rtl/gf_pipe_reg.sv
// One pipeline bank: valid bit plus data that loads only on valid
module gf_pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         v_in,
  input  logic [W-1:0] d_in,
  output logic         v_out,
  output logic [W-1:0] d_out
);

  always_ff @(posedge clk) begin
    if (rst) begin
      v_out <= 1'b0;
      d_out <= '0;
    end else begin
      v_out <= v_in;
      if (v_in) d_out <= d_in;
    end
  end

  // R6
  rst_clear_chk: assert property (@(posedge clk) rst |=> (!v_out && d_out == '0))
    else $error("pipeline bank not cleared by reset");

  // R7
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !v_in |=> $stable(d_out))
    else $error("pipeline bank data changed without valid");

endmodule

// File: rtl/gf_mul_pipe.sv
module gf_mul_pipe
  import gf_mul_pkg::*;
#(
  parameter int         W    = SYM_W,
  parameter logic [W:0] POLY = FIELD_PY,
  localparam int        PW   = 2 * W - 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic         out_valid,
  output logic [W-1:0] p_out
);

  logic [PW-1:0] clp_c;
  logic [PW-1:0] clp_q;
  logic          mid_v;
  logic [W-1:0]  red_c;

  gf_clmul #(.W(W)) u_clmul (
    .op_a (a_in),
    .op_b (b_in),
    .clp  (clp_c)
  );

  gf_pipe_reg #(.W(PW)) u_mid (
    .clk   (clk),
    .rst   (rst),
    .v_in  (in_valid),
    .d_in  (clp_c),
    .v_out (mid_v),
    .d_out (clp_q)
  );

  gf_reduce #(.W(W), .POLY(POLY)) u_reduce (
    .clp (clp_q),
    .sym (red_c)
  );

  gf_pipe_reg #(.W(W)) u_out (
    .clk   (clk),
    .rst   (rst),
    .v_in  (mid_v),
    .d_in  (red_c),
    .v_out (out_valid),
    .d_out (p_out)
  );

  // R2
  valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(rst, 2)) |-> (out_valid == $past(in_valid, 2)))
    else $error("out_valid is not in_valid delayed by two");

  // R4
  zero_op_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(rst, 2) && out_valid &&
       ($past(a_in, 2) == '0 || $past(b_in, 2) == '0)) |-> (p_out == '0))
    else $error("zero operand gave nonzero product");

  // R5
  one_op_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(rst, 2) && out_valid && $past(a_in, 2) == W'(1))
      |-> (p_out == $past(b_in, 2)))
    else $error("unit operand did not pass other operand");

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !out_valid) |-> $stable(p_out))
    else $error("p_out moved while out_valid low");

endmodule

// File: tb/tb_gf_mul_pipe.sv
module tb_gf_mul_pipe;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [W-1:0] a_in, b_in;
  logic         out_valid;
  logic [W-1:0] p_out;

  always #4 clk = ~clk;  // 125 MHz

  gf_mul_pipe dut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .a_in(a_in), .b_in(b_in),
    .out_valid(out_valid), .p_out(p_out)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  int exp_t [0:254];
  int log_t [0:255];

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [W-1:0] p;
    int           stamp;
  } item_t;

  item_t sb_q[$];
  logic [W-1:0] last_exp = '0;
  int run_len = 0;
  int max_run = 0;
  bit sb_clear = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b);
    if (a == 0 || b == 0) return '0;
    return W'(exp_t[(log_t[a] + log_t[b]) % 255]);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // driver: one operand pair per call, pushes expected item
  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1;
    a_in = a;
    b_in = b;
    it.a = a; it.b = b; it.p = model(a, b); it.stamp = cyc;
    sb_q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      a_in = 8'hA5;
      b_in = 8'h5A;
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_clear) begin
        sb_q.delete();
        sb_clear = 1'b0;
      end
      if (rst) begin
        run_len = 0;
      end else if (out_valid) begin
        run_len++;
        if (run_len > max_run) max_run = run_len;
        if (sb_q.size() == 0) begin
          check(1'b0, "R2", 1, 0);
        end else begin
          item_t it;
          string req;
          it = sb_q.pop_front();
          if (it.a == 0 || it.b == 0)      req = "R4";
          else if (it.a == 1 || it.b == 1) req = "R5";
          else                             req = "R1";
          check(p_out == it.p, req, p_out, it.p);
          // R2: latency of exactly two edges
          if (cyc != it.stamp + 2) check(1'b0, "R2", cyc - it.stamp, 2);
          last_exp = it.p;
        end
      end else begin
        run_len = 0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    int v;
    logic [15:0] lf;
    v = 1;
    for (int e = 0; e < 255; e++) begin
      exp_t[e] = v;
      log_t[v] = e;
      v = v << 1;
      if ((v & 256) != 0) v = v ^ 'h11D;
    end
    log_t[0] = 0;

    rst = 1'b1; in_valid = 1'b0; a_in = '0; b_in = '0;
    repeat (4) @(negedge clk);
    // R6: reset state
    check(out_valid == 1'b0, "R6", out_valid, 0);
    check(p_out == '0, "R6", p_out, 0);
    rst = 1'b0;
    idle(2);
    // R7: idle output after reset stays zero
    check(p_out == '0, "R7", p_out, 0);

    // exhaustive sweep, a bubble after every 512 pairs (R1, R3, R4, R5)
    for (int i = 0; i < 65536; i++) begin
      drive(W'(i >> 8), W'(i));
      if ((i % 512) == 511) idle(1);
    end
    idle(4);
    // R3: longest gapless run of results
    check(max_run >= 512, "R3", max_run, 512);
    check(sb_q.size() == 0, "R2", sb_q.size(), 0);

    // pseudo-random operands with irregular gaps
    lf = 16'hACE1;
    for (int i = 0; i < 2000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      drive(lf[7:0], lf[15:8]);
      if (lf[3:2] == 2'b00) idle(1 + int'(lf[5:4]));
    end
    idle(4);
    check(sb_q.size() == 0, "R2", sb_q.size(), 0);

    // R7: output holds the last result across idle cycles
    for (int i = 0; i < 8; i++) begin
      idle(1);
      check(p_out == last_exp, "R7", p_out, last_exp);
    end

    // R6: reset with both stages full
    drive(8'h53, 8'hCA);
    drive(8'h02, 8'h80);
    drive(8'hFF, 8'hFF);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    sb_q.delete();
    check(out_valid == 1'b0, "R6", out_valid, 0);
    check(p_out == '0, "R6", p_out, 0);
    @(negedge clk);
    rst = 1'b0;
    // anything in flight emerging now hits an empty scoreboard (R2/R6)
    for (int i = 0; i < 4; i++) begin
      idle(1);
      check(out_valid == 1'b0, "R6", out_valid, 0);
    end

    // after reset, a fresh back-to-back burst still works (R1, R3)
    drive(8'h02, 8'h80);
    drive(8'h80, 8'h80);
    drive(8'h01, 8'h9C);
    idle(4);
    check(sb_q.size() == 0, "R2", sb_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule